// File: doc/BRIEF.md
# Directory-Coherent Cache Node Controller

This block is the cache-side coherence engine of one processor node in a shared-memory system that has no broadcast bus. Coherence is kept by a home directory that exchanges explicit, typed messages with each node. The controller holds a small direct-mapped cache, one data word per line. Every line is in one of three states: Invalid, Shared (readable copy) or Exclusive (sole, writable and dirty copy). A CPU access that the line state cannot satisfy becomes a point-to-point request to the home. The access then waits for the data reply before it completes.

The home can also send the node three kinds of message. An invalidate drops a readable copy. A fetch pulls back dirty data and keeps a readable copy. A fetch-with-invalidate pulls back dirty data and drops the line. The processor is blocked for the whole of an access. The network delivers messages in the order they were sent, so the controller acts on incoming messages strictly in arrival order, including while it waits for a reply.

All three message and request paths use valid/ready handshakes. The outgoing message port holds its type, node number, address and data stable while valid is high and ready is low. Nothing changes until the home accepts the message. The incoming port lowers ready while the node is busy sending a message, so the network must hold the message until it is accepted. The CPU request port is ready only when the controller is idle and no incoming message is waiting. The CPU response is a one-cycle valid pulse with no back-pressure, because the processor is stalled and always waiting for it. Message codes (3 bits) are: 1 read miss, 2 write miss, 3 data write-back, 4 invalidate, 5 fetch, 6 fetch-with-invalidate, 7 data reply; 0 is reserved.

Top module: `dcc_node`

## Requirements
- R1: A CPU read of a line that is not present sends a read-miss message (code 1) carrying this node's number and the full word address. When the data reply (code 7) is accepted, the CPU response returns the reply data and the line becomes Shared.
- R2: A CPU write to a line that is absent, or present only as Shared, sends a write-miss message (code 2). When the reply is accepted, the line becomes Exclusive and holds the CPU write data, and the CPU response returns that write data.
- R3: A miss whose target index holds an Exclusive line with a different tag first sends a data write-back (code 3) with the victim's address and data. The read-miss or write-miss follows only after that write-back.
- R4: An incoming invalidate (code 4) whose address matches a Shared line makes that line Invalid, so the next read of it sends a read-miss.
- R5: An incoming fetch (code 5) whose address matches an Exclusive line sends a data write-back with that address and the line's data, and leaves the line Shared. A later read then hits, and a later write sends a write-miss.
- R6: An incoming fetch-with-invalidate (code 6) whose address matches an Exclusive line sends a data write-back with the line's data and makes the line Invalid.
- R7: An incoming invalidate or fetch that matches no line in the needed state, and a data reply that arrives while no miss is pending, are accepted with no outgoing message and no change to any line.
- R8: While an outgoing message is valid and not accepted, it stays valid with unchanged type, address and data. The outgoing type is always 1, 2 or 3.
- R9: CPU request ready is low from the acceptance of a missing access until its reply completes it, and is low whenever an incoming message is valid (incoming messages take priority).
- R10: While the node waits for a data reply, it still accepts incoming invalidates and fetches and acts on them in arrival order, before the reply that follows.
- R11: After reset every line is Invalid, no outgoing message or response is valid, and both the CPU request port and the incoming port are ready.
- R12: A read hitting a Shared or Exclusive line, or a write hitting an Exclusive line, produces the response in the next cycle with no outgoing message. A write hit also updates the line's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | CPU access request valid |
| cpu_req_ready | output | 1 | Controller accepts a CPU request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address of the access |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | One-cycle pulse: access complete |
| cpu_rsp_rdata | output | DATA_W | Read data, or the written data for a write |
| msg_out_valid | output | 1 | Outgoing message valid |
| msg_out_ready | input | 1 | Network accepts the outgoing message |
| msg_out_type | output | 3 | Outgoing message code (1, 2 or 3) |
| msg_out_node | output | NODE_W | Number of this node |
| msg_out_addr | output | ADDR_W | Address carried by the message |
| msg_out_data | output | DATA_W | Write-back data (zero for misses) |
| msg_in_valid | input | 1 | Incoming message valid |
| msg_in_ready | output | 1 | Controller accepts the incoming message |
| msg_in_type | input | 3 | Incoming message code (4, 5, 6 or 7) |
| msg_in_addr | input | ADDR_W | Address of the incoming message |
| msg_in_data | input | DATA_W | Data of a reply |

## Verification
The hardest situation to reach from the ports is a fetch-with-invalidate for one line that lands while a miss on a different line is still waiting for its reply. The controller must send a write-back in the middle of its own pending transaction and then return to waiting. The bench reaches it by first making a line Exclusive, then issuing a miss to another index. It lets that read-miss drain to the home model and injects the fetch before returning the reply. Sharing transitions are driven with the outgoing port under periodic back-pressure, so every message is also compared after being held.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHD = 2'd1,
    LN_EXC = 2'd2
  } line_st_e;

  localparam logic [2:0] MSG_RD_MISS   = 3'd1;
  localparam logic [2:0] MSG_WR_MISS   = 3'd2;
  localparam logic [2:0] MSG_WBACK     = 3'd3;
  localparam logic [2:0] MSG_INVAL     = 3'd4;
  localparam logic [2:0] MSG_FETCH     = 3'd5;
  localparam logic [2:0] MSG_FETCH_INV = 3'd6;
  localparam logic [2:0] MSG_REPLY     = 3'd7;

  typedef enum logic [2:0] {
    F_IDLE = 3'd0,
    F_VICT = 3'd1,
    F_MISS = 3'd2,
    F_WAIT = 3'd3,
    F_FWB  = 3'd4
  } fsm_e;
endpackage

// File: rtl/dcc_line_store.sv
module dcc_line_store
  import dcc_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 10,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_e          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_e          b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  line_st_e          wr_st,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LN_INV;
    end else if (wr_en) begin
      st_q[wr_idx] <= wr_st;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_data = data_q[b_idx];
endmodule

// File: rtl/dcc_out_port.sv
module dcc_out_port #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [2:0]        ld_type,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [2:0]        out_type,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              fire
);
  assign fire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_type  <= '0;
      out_addr  <= '0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_type  <= ld_type;
      out_addr  <= ld_addr;
      out_data  <= ld_data;
    end else if (fire) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dcc_fsm.sv
module dcc_fsm
  import dcc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int LINES  = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_type,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic [IDX_W-1:0]  a_idx,
  input  line_st_e          a_st,
  input  logic [TAG_W-1:0]  a_tag,
  input  logic [DATA_W-1:0] a_data,
  output logic [IDX_W-1:0]  b_idx,
  input  line_st_e          b_st,
  input  logic [TAG_W-1:0]  b_tag,
  input  logic [DATA_W-1:0] b_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output line_st_e          wr_st,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data,
  output logic              ld,
  output logic [2:0]        ld_type,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data,
  input  logic              out_fire
);
  fsm_e              st_q, st_d, ret_q, ret_d;
  logic              req_we_q, req_we_d;
  logic [ADDR_W-1:0] req_addr_q, req_addr_d;
  logic [DATA_W-1:0] req_wdata_q, req_wdata_d;
  logic              rsp_v_q, rsp_v_d;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;

  logic              in_fire, cpu_fire, a_hit, b_hit;
  logic [TAG_W-1:0]  cpu_tag, in_tag, req_tag;
  logic [IDX_W-1:0]  req_idx;

  assign in_ready      = (st_q == F_IDLE) || (st_q == F_WAIT);
  assign in_fire       = in_valid && in_ready;
  assign cpu_req_ready = (st_q == F_IDLE) && !in_valid;
  assign cpu_fire      = cpu_req_valid && cpu_req_ready;

  assign a_idx   = cpu_req_addr[IDX_W-1:0];
  assign cpu_tag = cpu_req_addr[ADDR_W-1:IDX_W];
  assign b_idx   = in_addr[IDX_W-1:0];
  assign in_tag  = in_addr[ADDR_W-1:IDX_W];
  assign req_idx = req_addr_q[IDX_W-1:0];
  assign req_tag = req_addr_q[ADDR_W-1:IDX_W];

  assign a_hit = (a_st != LN_INV) && (a_tag == cpu_tag);
  assign b_hit = (b_st != LN_INV) && (b_tag == in_tag);

  assign cpu_rsp_valid = rsp_v_q;
  assign cpu_rsp_rdata = rsp_data_q;

  always_comb begin
    st_d        = st_q;
    ret_d       = ret_q;
    req_we_d    = req_we_q;
    req_addr_d  = req_addr_q;
    req_wdata_d = req_wdata_q;
    rsp_v_d     = 1'b0;
    rsp_data_d  = rsp_data_q;
    wr_en       = 1'b0;
    wr_idx      = a_idx;
    wr_st       = LN_INV;
    wr_tag      = a_tag;
    wr_data     = a_data;
    ld          = 1'b0;
    ld_type     = MSG_RD_MISS;
    ld_addr     = req_addr_q;
    ld_data     = '0;
    case (st_q)
      F_IDLE, F_WAIT: begin
        if (in_fire) begin
          case (in_type)
            MSG_INVAL: begin
              if (b_hit && b_st == LN_SHD) begin
                wr_en   = 1'b1;
                wr_idx  = b_idx;
                wr_st   = LN_INV;
                wr_tag  = b_tag;
                wr_data = b_data;
              end
            end
            MSG_FETCH, MSG_FETCH_INV: begin
              if (b_hit && b_st == LN_EXC) begin
                wr_en   = 1'b1;
                wr_idx  = b_idx;
                wr_st   = (in_type == MSG_FETCH) ? LN_SHD : LN_INV;
                wr_tag  = b_tag;
                wr_data = b_data;
                ld      = 1'b1;
                ld_type = MSG_WBACK;
                ld_addr = in_addr;
                ld_data = b_data;
                ret_d   = st_q;
                st_d    = F_FWB;
              end
            end
            MSG_REPLY: begin
              if (st_q == F_WAIT) begin
                wr_en      = 1'b1;
                wr_idx     = req_idx;
                wr_st      = req_we_q ? LN_EXC : LN_SHD;
                wr_tag     = req_tag;
                wr_data    = req_we_q ? req_wdata_q : in_data;
                rsp_v_d    = 1'b1;
                rsp_data_d = req_we_q ? req_wdata_q : in_data;
                st_d       = F_IDLE;
              end
            end
            default: ;
          endcase
        end else if (cpu_fire) begin
          if (a_hit && !cpu_req_write) begin
            rsp_v_d    = 1'b1;
            rsp_data_d = a_data;
          end else if (a_hit && a_st == LN_EXC) begin
            wr_en      = 1'b1;
            wr_st      = LN_EXC;
            wr_data    = cpu_req_wdata;
            rsp_v_d    = 1'b1;
            rsp_data_d = cpu_req_wdata;
          end else begin
            req_we_d    = cpu_req_write;
            req_addr_d  = cpu_req_addr;
            req_wdata_d = cpu_req_wdata;
            wr_en       = 1'b1;
            wr_st       = LN_INV;
            ld          = 1'b1;
            if (a_st == LN_EXC) begin
              ld_type = MSG_WBACK;
              ld_addr = {a_tag, a_idx};
              ld_data = a_data;
              st_d    = F_VICT;
            end else begin
              ld_type = cpu_req_write ? MSG_WR_MISS : MSG_RD_MISS;
              ld_addr = cpu_req_addr;
              st_d    = F_MISS;
            end
          end
        end
      end
      F_VICT: begin
        if (out_fire) begin
          ld      = 1'b1;
          ld_type = req_we_q ? MSG_WR_MISS : MSG_RD_MISS;
          ld_addr = req_addr_q;
          st_d    = F_MISS;
        end
      end
      F_MISS: if (out_fire) st_d = F_WAIT;
      F_FWB:  if (out_fire) st_d = ret_q;
      default: st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= F_IDLE;
      ret_q       <= F_IDLE;
      req_we_q    <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      rsp_v_q     <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      st_q        <= st_d;
      ret_q       <= ret_d;
      req_we_q    <= req_we_d;
      req_addr_q  <= req_addr_d;
      req_wdata_q <= req_wdata_d;
      rsp_v_q     <= rsp_v_d;
      rsp_data_q  <= rsp_data_d;
    end
  end
endmodule

// File: rtl/dcc_node.sv
module dcc_node
  import dcc_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 16,
  parameter int NODE_W  = 2,
  parameter int NODE_ID = 1,
  parameter int LINES   = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              msg_out_valid,
  input  logic              msg_out_ready,
  output logic [2:0]        msg_out_type,
  output logic [NODE_W-1:0] msg_out_node,
  output logic [ADDR_W-1:0] msg_out_addr,
  output logic [DATA_W-1:0] msg_out_data,
  input  logic              msg_in_valid,
  output logic              msg_in_ready,
  input  logic [2:0]        msg_in_type,
  input  logic [ADDR_W-1:0] msg_in_addr,
  input  logic [DATA_W-1:0] msg_in_data
);
  logic [IDX_W-1:0]  a_idx, b_idx, wr_idx;
  line_st_e          a_st, b_st, wr_st;
  logic [TAG_W-1:0]  a_tag, b_tag, wr_tag;
  logic [DATA_W-1:0] a_data, b_data, wr_data, ld_data;
  logic              wr_en, ld, out_fire;
  logic [2:0]        ld_type;
  logic [ADDR_W-1:0] ld_addr;

  assign msg_out_node = NODE_W'(NODE_ID);

  dcc_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(a_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
    .b_idx(b_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_st(wr_st), .wr_tag(wr_tag), .wr_data(wr_data)
  );

  dcc_out_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .load(ld), .ld_type(ld_type), .ld_addr(ld_addr), .ld_data(ld_data),
    .out_ready(msg_out_ready), .out_valid(msg_out_valid), .out_type(msg_out_type),
    .out_addr(msg_out_addr), .out_data(msg_out_data), .fire(out_fire)
  );

  dcc_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_rdata(cpu_rsp_rdata),
    .in_valid(msg_in_valid), .in_ready(msg_in_ready), .in_type(msg_in_type),
    .in_addr(msg_in_addr), .in_data(msg_in_data),
    .a_idx(a_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
    .b_idx(b_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_st(wr_st), .wr_tag(wr_tag), .wr_data(wr_data),
    .ld(ld), .ld_type(ld_type), .ld_addr(ld_addr), .ld_data(ld_data),
    .out_fire(out_fire)
  );
endmodule

// File: rtl/dcc_node_chk.sv
module dcc_node_chk #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 16,
  parameter int NODE_W  = 2,
  parameter int NODE_ID = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              msg_out_valid,
  input logic              msg_out_ready,
  input logic [2:0]        msg_out_type,
  input logic [NODE_W-1:0] msg_out_node,
  input logic [ADDR_W-1:0] msg_out_addr,
  input logic [DATA_W-1:0] msg_out_data,
  input logic              msg_in_valid,
  input logic              msg_in_ready,
  input logic [2:0]        msg_in_type
);
  // R8: a held message keeps its content
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_out_valid && !msg_out_ready |=> msg_out_valid && $stable(msg_out_type)
      && $stable(msg_out_addr) && $stable(msg_out_data));

  // R8: only request and write-back codes leave the node
  assert_out_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_out_valid |-> (msg_out_type == 3'd1 || msg_out_type == 3'd2 || msg_out_type == 3'd3));

  // R1: every message carries the node number
  assert_out_node_R1: assert property (@(posedge clk) disable iff (!rst_n)
    msg_out_valid |-> msg_out_node == NODE_W'(NODE_ID));

  // R9: CPU is blocked while a message is outstanding
  assert_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_out_valid |-> !cpu_req_ready);

  // R9: incoming traffic has priority over a new CPU request
  assert_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_in_valid |-> !cpu_req_ready);

  // R12: a response follows a CPU acceptance or an accepted reply
  assert_rsp_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> $past(cpu_req_valid && cpu_req_ready)
      || $past(msg_in_valid && msg_in_ready && msg_in_type == 3'd7));
endmodule

bind dcc_node dcc_node_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NODE_W(NODE_W), .NODE_ID(NODE_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_rsp_valid(cpu_rsp_valid),
  .msg_out_valid(msg_out_valid), .msg_out_ready(msg_out_ready),
  .msg_out_type(msg_out_type), .msg_out_node(msg_out_node),
  .msg_out_addr(msg_out_addr), .msg_out_data(msg_out_data),
  .msg_in_valid(msg_in_valid), .msg_in_ready(msg_in_ready),
  .msg_in_type(msg_in_type)
);

// File: tb/dcc_node_tb.sv
module dcc_node_tb;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int NW = 2;
  localparam int NID = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic cpu_req_ready, cpu_rsp_valid;
  logic [DW-1:0] cpu_rsp_rdata;
  logic msg_out_valid, msg_out_ready = 1'b1;
  logic [2:0] msg_out_type;
  logic [NW-1:0] msg_out_node;
  logic [AW-1:0] msg_out_addr;
  logic [DW-1:0] msg_out_data;
  logic msg_in_valid = 1'b0, msg_in_ready;
  logic [2:0] msg_in_type = '0;
  logic [AW-1:0] msg_in_addr = '0;
  logic [DW-1:0] msg_in_data = '0;

  always #5 clk = ~clk;

  dcc_node #(.ADDR_W(AW), .DATA_W(DW), .NODE_W(NW), .NODE_ID(NID), .LINES(4)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_rdata(cpu_rsp_rdata),
    .msg_out_valid(msg_out_valid), .msg_out_ready(msg_out_ready),
    .msg_out_type(msg_out_type), .msg_out_node(msg_out_node),
    .msg_out_addr(msg_out_addr), .msg_out_data(msg_out_data),
    .msg_in_valid(msg_in_valid), .msg_in_ready(msg_in_ready),
    .msg_in_type(msg_in_type), .msg_in_addr(msg_in_addr), .msg_in_data(msg_in_data)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit bp_en = 1'b0, done = 1'b0;

  // reference model: line states 0 inv, 1 shared, 2 exclusive
  logic [1:0]    m_st  [4];
  logic [9:0]    m_tag [4];
  logic [DW-1:0] m_dat [4];
  bit            p_act = 1'b0, p_we = 1'b0, miss_flag = 1'b0;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_wd = '0;

  logic [2:0]    q_type [$];
  logic [AW-1:0] q_addr [$];
  logic [DW-1:0] q_data [$];
  string         q_req  [$];
  logic [DW-1:0] r_data [$];
  string         r_req  [$];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    msg_out_ready <= !bp_en || (cyc % 3 == 0);
  end

  // per-clock comparison against the model queues
  bit hold_pend = 1'b0;
  logic [63:0] hold_snap = '0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (hold_pend)
        chk("R8 held message", {30'd0, msg_out_valid, msg_out_type, msg_out_addr, msg_out_data},
            hold_snap);
      hold_pend = msg_out_valid && !msg_out_ready;
      hold_snap = {30'd0, msg_out_valid, msg_out_type, msg_out_addr, msg_out_data};
      if (msg_out_valid && msg_out_ready) begin
        if (q_type.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R7 unexpected message actual=%0h expected=none", msg_out_type);
        end else begin
          string rq;
          rq = q_req.pop_front();
          chk({rq, " type"}, 64'(msg_out_type), 64'(q_type.pop_front()));
          chk({rq, " addr"}, 64'(msg_out_addr), 64'(q_addr.pop_front()));
          chk({rq, " data"}, 64'(msg_out_data), 64'(q_data.pop_front()));
          chk("R1 node", 64'(msg_out_node), 64'(NID));
        end
      end
      if (cpu_rsp_valid) begin
        if (r_data.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R12 unexpected response actual=%0h expected=none", cpu_rsp_rdata);
        end else begin
          string rq;
          rq = r_req.pop_front();
          chk({rq, " rsp"}, 64'(cpu_rsp_rdata), 64'(r_data.pop_front()));
        end
      end
    end
  end

  task automatic push_msg(logic [2:0] t, logic [AW-1:0] a, logic [DW-1:0] d, string rq);
    q_type.push_back(t); q_addr.push_back(a); q_data.push_back(d); q_req.push_back(rq);
  endtask

  task automatic wait_out();
    for (int k = 0; k < 300 && q_type.size() != 0; k++) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic wait_rsp();
    for (int k = 0; k < 300 && r_data.size() != 0; k++) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic cpu_issue(bit we, logic [AW-1:0] a, logic [DW-1:0] d, string rq);
    logic [1:0] ix;
    bit hit;
    ix = a[1:0];
    @(posedge clk); #1;
    cpu_req_valid = 1'b1; cpu_req_write = we; cpu_req_addr = a; cpu_req_wdata = d;
    do @(negedge clk); while (!cpu_req_ready);
    hit = (m_st[ix] != 2'd0) && (m_tag[ix] == a[AW-1:2]);
    miss_flag = 1'b0;
    if (!we && hit) begin
      r_data.push_back(m_dat[ix]); r_req.push_back({rq, " R12 read hit"});
    end else if (we && hit && m_st[ix] == 2'd2) begin
      m_dat[ix] = d;
      r_data.push_back(d); r_req.push_back({rq, " R12 write hit"});
    end else begin
      if (m_st[ix] == 2'd2) push_msg(3'd3, {m_tag[ix], ix}, m_dat[ix], {rq, " R3 victim"});
      push_msg(we ? 3'd2 : 3'd1, a, '0, rq);
      m_st[ix] = 2'd0;
      p_act = 1'b1; p_we = we; p_addr = a; p_wd = d;
      miss_flag = 1'b1;
    end
    @(posedge clk); #1;
    cpu_req_valid = 1'b0;
  endtask

  task automatic send_in(logic [2:0] t, logic [AW-1:0] a, logic [DW-1:0] d);
    logic [1:0] ix;
    bit hit;
    ix = a[1:0];
    @(posedge clk); #1;
    msg_in_valid = 1'b1; msg_in_type = t; msg_in_addr = a; msg_in_data = d;
    do @(negedge clk); while (!msg_in_ready);
    hit = (m_st[ix] != 2'd0) && (m_tag[ix] == a[AW-1:2]);
    case (t)
      3'd4: if (hit && m_st[ix] == 2'd1) m_st[ix] = 2'd0;
      3'd5, 3'd6: if (hit && m_st[ix] == 2'd2) begin
        push_msg(3'd3, a, m_dat[ix], (t == 3'd5) ? "R5 fetch" : "R6 fetch-inv");
        m_st[ix] = (t == 3'd5) ? 2'd1 : 2'd0;
      end
      3'd7: if (p_act) begin
        m_st[p_addr[1:0]]  = p_we ? 2'd2 : 2'd1;
        m_tag[p_addr[1:0]] = p_addr[AW-1:2];
        m_dat[p_addr[1:0]] = p_we ? p_wd : d;
        r_data.push_back(p_we ? p_wd : d);
        r_req.push_back(p_we ? "R2 fill" : "R1 fill");
        p_act = 1'b0;
      end
      default: ;
    endcase
    @(posedge clk); #1;
    msg_in_valid = 1'b0;
    wait_out();
  endtask

  task automatic access(bit we, logic [AW-1:0] a, logic [DW-1:0] d, logic [DW-1:0] rep,
                        string rq);
    cpu_issue(we, a, d, rq);
    if (miss_flag) begin
      wait_out();
      @(negedge clk);
      chk("R9 blocked while waiting", 64'(cpu_req_ready), 64'd0);
      send_in(3'd7, a, rep);
    end
    wait_rsp();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_st[i] = 2'd0; m_tag[i] = '0; m_dat[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R11 cpu ready", 64'(cpu_req_ready), 64'd1);
    chk("R11 in ready", 64'(msg_in_ready), 64'd1);
    chk("R11 out valid", 64'(msg_out_valid), 64'd0);
    chk("R11 rsp valid", 64'(cpu_rsp_valid), 64'd0);
    // R11: empty cache, first read misses
    access(1'b0, 12'h010, '0, 16'hA1A1, "R1 R11 read miss");
    access(1'b0, 12'h010, '0, '0, "R12 shared");
    access(1'b1, 12'h010, 16'h1111, 16'h5555, "R2 upgrade");
    access(1'b1, 12'h010, 16'h2222, '0, "R12 excl");
    access(1'b0, 12'h010, '0, '0, "R12 excl read");
    bp_en = 1'b1;
    access(1'b0, 12'h020, '0, 16'h3333, "R3 R8 replace");
    send_in(3'd4, 12'h020, '0);
    access(1'b0, 12'h020, '0, 16'h4444, "R4 after inval");
    // R7: non-matching or wrong-state messages, stray reply
    send_in(3'd4, 12'h030, '0);
    send_in(3'd5, 12'h020, '0);
    send_in(3'd6, 12'h024, '0);
    send_in(3'd7, 12'h020, 16'hDEAD);
    access(1'b0, 12'h020, '0, '0, "R7 unchanged");
    access(1'b1, 12'h005, 16'h5A5A, 16'h0BAD, "R2 write miss");
    send_in(3'd5, 12'h005, '0);
    access(1'b0, 12'h005, '0, '0, "R5 shared read");
    access(1'b1, 12'h005, 16'h6B6B, 16'h0BAD, "R5 write after fetch");
    send_in(3'd6, 12'h005, '0);
    access(1'b0, 12'h005, '0, 16'h7C7C, "R6 reread");
    // R10: fetch-inv while a miss to another index is pending
    access(1'b1, 12'h006, 16'h8D8D, 16'h0BAD, "R10 setup");
    cpu_issue(1'b0, 12'h00B, '0, "R10 pending");
    wait_out();
    send_in(3'd6, 12'h006, '0);
    @(negedge clk);
    chk("R9 still blocked", 64'(cpu_req_ready), 64'd0);
    send_in(3'd7, 12'h00B, 16'h9E9E);
    wait_rsp();
    access(1'b0, 12'h006, '0, 16'hAFAF, "R10 line dropped");
    access(1'b0, 12'h00B, '0, '0, "R10 line filled");
    bp_en = 1'b0;
    repeat (4) @(posedge clk);
    chk("R10 messages drained", 64'(q_type.size()), 64'd0);
    chk("R12 responses drained", 64'(r_data.size()), 64'd0);
    finish_run();
  end
endmodule